// File: doc/BRIEF.md
# Link Bring-Up Reset Sequencer

This block is a synchronous controller that takes one serial-link slot from reset to a state in which configuration traffic may start. A one-cycle start pulse launches a run. The block first checks that a card is present. It then resets the link controller, lets the logic settle, and pulses the active-low slot reset. After that it polls for in-band presence and then for an active link. Before it declares the slot ready, it holds for a stability window and re-checks the link a programmable number of times.

Every wait is measured in periods of an external timebase tick, nominally 1 ms. A link that will not train, or that drops or gets fenced during the stability window, sends the block back to a full controller reset. The number of such retries is bounded. At the end of a run the block raises either ready or failed, and gives a cause code for a failure.

Top module: `link_bringup`

## Requirements
- R1: A start pulse with slotPresent low sets failed with cause 1 (empty slot) on the next clock. ctrlReset stays low and perstN keeps its value. The other cause codes are 0 = none, 2 = no electrical link, 3 = link won't train, 4 = link not stable.
- R2: Every attempt starts with ctrlReset high for CRST_TICKS ticks, followed by SETTLE_TICKS ticks before the slot-reset phase. A wait of N ticks counts only the ticks that arrive after the state is entered, so with a tick every cycle it lasts N+1 clocks.
- R3: perstN resets to 0. If perstN is already 0 when the settle wait ends, the assert phase is skipped and perstN is released at once. Otherwise perstN is driven low for PERST_TICKS ticks and then released.
- R4: POST_TICKS after release, polling starts. In-band presence is first sampled FIRST_TICKS later and then every POLL_TICKS. If it is still absent after ELEC_RETRIES further samples, the run ends failed with cause 2 and no retry.
- R5: Once in-band presence is seen, link-active is sampled FIRST_TICKS later and then every POLL_TICKS, for TRAIN_RETRIES+1 samples in total. If every sample is low, the retry path is taken.
- R6: The retry path returns to the ctrlReset step at most MAX_RETRIES times. When no retries remain, the run ends failed with the cause of the current phase (3 for training).
- R7: When link-active is first seen, the block waits STABLE_TICKS and checks fence and link. It repeats this wait-and-check until stableChecks+1 checks have passed, then sets ready.
- R8: A stability check that finds fenced high or linkActive low takes the retry path. An exhausted budget ends the run failed with cause 4.
- R9: ready and failed are never high together. Each is held until the next start pulse, which clears both. cause is 0 while ready is high. A start pulse during a run is ignored.
- R10: Wait counters advance only on tick. A tick-free gap stretches the current wait by the gap length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Launches a run when idle |
| tick | input | 1 | Timebase tick, one cycle wide |
| slotPresent | input | 1 | A card sits in the slot |
| inbandPresent | input | 1 | Electrical presence reported by the link |
| linkActive | input | 1 | Link trained and active |
| fenced | input | 1 | Link controller is fenced |
| stableChecks | input | CHECK_W | Extra stability checks after the first |
| ctrlReset | output | 1 | Full controller reset, active high |
| perstN | output | 1 | Slot reset, active low |
| ready | output | 1 | Slot usable, sticky |
| failed | output | 1 | Run failed, sticky |
| cause | output | 3 | Failure cause code |

## Verification
The bench aims at the first run after reset, where perstN is already low. A design that asserted it anyway would stretch the low time, and one that never re-asserted it would show no slot-reset pulse on later runs. It counts controller-reset pulses across failing runs, for both a link that never trains and a link that stays fenced. An off-by-one retry budget shows up as one pulse too many or too few, and a fence recovery that does not restart from controller reset fails to reach ready. Sweeping stableChecks and timing the release-to-ready interval exposes a wrong number of stability checks or a wrong reload of the wait. A tick gap during the assert phase catches a timer that runs on the clock rather than on the tick.

// File: rtl/lnkbr_pkg.sv
package lnkbr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CRST,
    ST_SETTLE,
    ST_PERST,
    ST_POST,
    ST_ELEC,
    ST_TRAIN,
    ST_STABLE
  } state_e;

  typedef enum logic [2:0] {
    W_CRST,
    W_SETTLE,
    W_PERST,
    W_POST,
    W_FIRST,
    W_POLL,
    W_STABLE
  } waitSel_e;

  typedef enum logic [1:0] {
    P_ELEC,
    P_TRAIN,
    P_STABLE
  } pollSel_e;

  typedef enum logic [2:0] {
    C_NONE     = 3'd0,
    C_EMPTY    = 3'd1,
    C_NOELEC   = 3'd2,
    C_NOTRAIN  = 3'd3,
    C_UNSTABLE = 3'd4
  } cause_e;

  typedef struct packed {
    logic     loadTimer;
    waitSel_e waitSel;
    logic     loadPoll;
    pollSel_e pollSel;
    logic     decPoll;
    logic     loadRetry;
    logic     decRetry;
  } strobes_t;

endpackage

// File: rtl/lnkbr_dcnt.sv
module lnkbr_dcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= loadVal;
    end else if (dec && (cnt != '0)) begin
      cnt <= cnt - W'(1);
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/lnkbr_dp.sv
module lnkbr_dp
  import lnkbr_pkg::*;
#(
  parameter int CRST_TICKS    = 1,
  parameter int SETTLE_TICKS  = 10,
  parameter int PERST_TICKS   = 250,
  parameter int POST_TICKS    = 1,
  parameter int FIRST_TICKS   = 1,
  parameter int POLL_TICKS    = 10,
  parameter int STABLE_TICKS  = 1000,
  parameter int ELEC_RETRIES  = 10,
  parameter int TRAIN_RETRIES = 200,
  parameter int MAX_RETRIES   = 3,
  parameter int CHECK_W       = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  strobes_t           stb,
  input  logic [CHECK_W-1:0] stableChecks,
  output logic               timerDone,
  output logic               pollZero,
  output logic               retryZero
);

  localparam int MAX_A    = (CRST_TICKS > SETTLE_TICKS) ? CRST_TICKS : SETTLE_TICKS;
  localparam int MAX_B    = (PERST_TICKS > POST_TICKS) ? PERST_TICKS : POST_TICKS;
  localparam int MAX_C    = (FIRST_TICKS > POLL_TICKS) ? FIRST_TICKS : POLL_TICKS;
  localparam int MAX_AB   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CD   = (MAX_C > STABLE_TICKS) ? MAX_C : STABLE_TICKS;
  localparam int TMR_MAX  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TW       = $clog2(TMR_MAX + 2);
  localparam int CHK_MAX  = (1 << CHECK_W) - 1;
  localparam int POLL_ET  = (ELEC_RETRIES > TRAIN_RETRIES) ? ELEC_RETRIES : TRAIN_RETRIES;
  localparam int POLL_MAX = (POLL_ET > CHK_MAX) ? POLL_ET : CHK_MAX;
  localparam int PW       = $clog2(POLL_MAX + 2);
  localparam int RW       = $clog2(MAX_RETRIES + 2);

  logic [TW-1:0] tmrLoad;
  logic [PW-1:0] pollLoad;

  always_comb begin
    case (stb.waitSel)
      W_CRST:   tmrLoad = TW'(CRST_TICKS);
      W_SETTLE: tmrLoad = TW'(SETTLE_TICKS);
      W_PERST:  tmrLoad = TW'(PERST_TICKS);
      W_POST:   tmrLoad = TW'(POST_TICKS);
      W_FIRST:  tmrLoad = TW'(FIRST_TICKS);
      W_POLL:   tmrLoad = TW'(POLL_TICKS);
      default:  tmrLoad = TW'(STABLE_TICKS);
    endcase
  end

  always_comb begin
    case (stb.pollSel)
      P_ELEC:  pollLoad = PW'(ELEC_RETRIES);
      P_TRAIN: pollLoad = PW'(TRAIN_RETRIES);
      default: pollLoad = PW'(stableChecks);
    endcase
  end

  lnkbr_dcnt #(.W(TW)) u_timer (
    .clk     (clk),
    .rstN    (rstN),
    .load    (stb.loadTimer),
    .loadVal (tmrLoad),
    .dec     (tick),
    .zero    (timerDone)
  );

  lnkbr_dcnt #(.W(PW)) u_polls (
    .clk     (clk),
    .rstN    (rstN),
    .load    (stb.loadPoll),
    .loadVal (pollLoad),
    .dec     (stb.decPoll),
    .zero    (pollZero)
  );

  lnkbr_dcnt #(.W(RW)) u_retries (
    .clk     (clk),
    .rstN    (rstN),
    .load    (stb.loadRetry),
    .loadVal (RW'(MAX_RETRIES)),
    .dec     (stb.decRetry),
    .zero    (retryZero)
  );

endmodule

// File: rtl/lnkbr_ctrl.sv
module lnkbr_ctrl
  import lnkbr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startPulse,
  input  logic     slotPresent,
  input  logic     inbandPresent,
  input  logic     linkActive,
  input  logic     fenced,
  input  logic     timerDone,
  input  logic     pollZero,
  input  logic     retryZero,
  output strobes_t stb,
  output logic     ctrlReset,
  output logic     perstN,
  output logic     ready,
  output logic     failed,
  output logic [2:0] cause
);

  state_e st, stNxt;
  logic   perstNxt, readyNxt, failedNxt;
  cause_e causeQ, causeNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      perstN <= 1'b0;
      ready  <= 1'b0;
      failed <= 1'b0;
      causeQ <= C_NONE;
    end else begin
      st     <= stNxt;
      perstN <= perstNxt;
      ready  <= readyNxt;
      failed <= failedNxt;
      causeQ <= causeNxt;
    end
  end

  assign ctrlReset = (st == ST_CRST);
  assign cause     = causeQ;

  always_comb begin
    stNxt     = st;
    perstNxt  = perstN;
    readyNxt  = ready;
    failedNxt = failed;
    causeNxt  = causeQ;
    stb       = '0;

    unique case (st)
      ST_IDLE: begin
        if (startPulse) begin
          readyNxt  = 1'b0;
          failedNxt = 1'b0;
          causeNxt  = C_NONE;
          if (!slotPresent) begin
            failedNxt = 1'b1;
            causeNxt  = C_EMPTY;
          end else begin
            stNxt         = ST_CRST;
            stb.loadTimer = 1'b1;
            stb.waitSel   = W_CRST;
            stb.loadRetry = 1'b1;
          end
        end
      end

      ST_CRST: begin
        if (timerDone) begin
          stNxt         = ST_SETTLE;
          stb.loadTimer = 1'b1;
          stb.waitSel   = W_SETTLE;
        end
      end

      ST_SETTLE: begin
        if (timerDone) begin
          stb.loadTimer = 1'b1;
          if (!perstN) begin
            perstNxt    = 1'b1;
            stNxt       = ST_POST;
            stb.waitSel = W_POST;
          end else begin
            perstNxt    = 1'b0;
            stNxt       = ST_PERST;
            stb.waitSel = W_PERST;
          end
        end
      end

      ST_PERST: begin
        if (timerDone) begin
          perstNxt      = 1'b1;
          stNxt         = ST_POST;
          stb.loadTimer = 1'b1;
          stb.waitSel   = W_POST;
        end
      end

      ST_POST: begin
        if (timerDone) begin
          stNxt         = ST_ELEC;
          stb.loadTimer = 1'b1;
          stb.waitSel   = W_FIRST;
          stb.loadPoll  = 1'b1;
          stb.pollSel   = P_ELEC;
        end
      end

      ST_ELEC: begin
        if (timerDone) begin
          if (inbandPresent) begin
            stNxt         = ST_TRAIN;
            stb.loadTimer = 1'b1;
            stb.waitSel   = W_FIRST;
            stb.loadPoll  = 1'b1;
            stb.pollSel   = P_TRAIN;
          end else if (pollZero) begin
            stNxt     = ST_IDLE;
            failedNxt = 1'b1;
            causeNxt  = C_NOELEC;
          end else begin
            stb.decPoll   = 1'b1;
            stb.loadTimer = 1'b1;
            stb.waitSel   = W_POLL;
          end
        end
      end

      ST_TRAIN: begin
        if (timerDone) begin
          if (linkActive) begin
            stNxt         = ST_STABLE;
            stb.loadTimer = 1'b1;
            stb.waitSel   = W_STABLE;
            stb.loadPoll  = 1'b1;
            stb.pollSel   = P_STABLE;
          end else if (pollZero) begin
            readyNxt = 1'b0;
            if (retryZero) begin
              stNxt     = ST_IDLE;
              failedNxt = 1'b1;
              causeNxt  = C_NOTRAIN;
            end else begin
              stNxt         = ST_CRST;
              stb.decRetry  = 1'b1;
              stb.loadTimer = 1'b1;
              stb.waitSel   = W_CRST;
            end
          end else begin
            stb.decPoll   = 1'b1;
            stb.loadTimer = 1'b1;
            stb.waitSel   = W_POLL;
          end
        end
      end

      ST_STABLE: begin
        if (timerDone) begin
          if (fenced || !linkActive) begin
            readyNxt = 1'b0;
            if (retryZero) begin
              stNxt     = ST_IDLE;
              failedNxt = 1'b1;
              causeNxt  = C_UNSTABLE;
            end else begin
              stNxt         = ST_CRST;
              stb.decRetry  = 1'b1;
              stb.loadTimer = 1'b1;
              stb.waitSel   = W_CRST;
            end
          end else if (pollZero) begin
            stNxt    = ST_IDLE;
            readyNxt = 1'b1;
          end else begin
            stb.decPoll   = 1'b1;
            stb.loadTimer = 1'b1;
            stb.waitSel   = W_STABLE;
          end
        end
      end

      default: stNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/link_bringup.sv
module link_bringup
  import lnkbr_pkg::*;
#(
  parameter int CRST_TICKS    = 1,
  parameter int SETTLE_TICKS  = 10,
  parameter int PERST_TICKS   = 250,
  parameter int POST_TICKS    = 1,
  parameter int FIRST_TICKS   = 1,
  parameter int POLL_TICKS    = 10,
  parameter int STABLE_TICKS  = 1000,
  parameter int ELEC_RETRIES  = 10,
  parameter int TRAIN_RETRIES = 200,
  parameter int MAX_RETRIES   = 3,
  parameter int CHECK_W       = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               tick,
  input  logic               slotPresent,
  input  logic               inbandPresent,
  input  logic               linkActive,
  input  logic               fenced,
  input  logic [CHECK_W-1:0] stableChecks,
  output logic               ctrlReset,
  output logic               perstN,
  output logic               ready,
  output logic               failed,
  output logic [2:0]         cause
);

  strobes_t stb;
  logic     timerDone, pollZero, retryZero;

  lnkbr_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .startPulse    (startPulse),
    .slotPresent   (slotPresent),
    .inbandPresent (inbandPresent),
    .linkActive    (linkActive),
    .fenced        (fenced),
    .timerDone     (timerDone),
    .pollZero      (pollZero),
    .retryZero     (retryZero),
    .stb           (stb),
    .ctrlReset     (ctrlReset),
    .perstN        (perstN),
    .ready         (ready),
    .failed        (failed),
    .cause         (cause)
  );

  lnkbr_dp #(
    .CRST_TICKS    (CRST_TICKS),
    .SETTLE_TICKS  (SETTLE_TICKS),
    .PERST_TICKS   (PERST_TICKS),
    .POST_TICKS    (POST_TICKS),
    .FIRST_TICKS   (FIRST_TICKS),
    .POLL_TICKS    (POLL_TICKS),
    .STABLE_TICKS  (STABLE_TICKS),
    .ELEC_RETRIES  (ELEC_RETRIES),
    .TRAIN_RETRIES (TRAIN_RETRIES),
    .MAX_RETRIES   (MAX_RETRIES),
    .CHECK_W       (CHECK_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .tick         (tick),
    .stb          (stb),
    .stableChecks (stableChecks),
    .timerDone    (timerDone),
    .pollZero     (pollZero),
    .retryZero    (retryZero)
  );

endmodule

// File: rtl/link_bringup_chk.sv
module link_bringup_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startPulse,
  input logic       ctrlReset,
  input logic       perstN,
  input logic       ready,
  input logic       failed,
  input logic [2:0] cause
);

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(ready && failed));

  assert_ready_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !startPulse) |=> ready);

  assert_failed_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (failed && !startPulse) |=> failed);

  assert_ready_no_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (cause == 3'd0));

  assert_empty_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (failed && cause == 3'd1) |-> (!ctrlReset && $stable(perstN)));

  assert_reset_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReset |-> (!ready && !failed));

  assert_release_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(perstN) |-> !ctrlReset);

  assert_fail_has_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failed) |-> (cause != 3'd0));

endmodule

bind link_bringup link_bringup_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .ctrlReset  (ctrlReset),
  .perstN     (perstN),
  .ready      (ready),
  .failed     (failed),
  .cause      (cause)
);

// File: tb/link_bringup_tb.sv
module link_bringup_tb;

  localparam int CRST   = 2;
  localparam int SETTLE = 3;
  localparam int PERST  = 5;
  localparam int POST   = 1;
  localparam int FIRST  = 1;
  localparam int POLL   = 2;
  localparam int STABLE = 6;
  localparam int ELEC   = 3;
  localparam int TRAIN  = 4;
  localparam int MAXR   = 2;
  localparam int CW     = 3;

  logic clk = 0, rstN = 0, startPulse = 0, tick = 1;
  logic slotPresent = 0, inbandPresent = 0, linkActive = 0, fenced = 0;
  logic [CW-1:0] stableChecks = '0;
  logic ctrlReset, perstN, ready, failed;
  logic [2:0] cause;

  always #4 clk = ~clk;

  link_bringup #(
    .CRST_TICKS(CRST), .SETTLE_TICKS(SETTLE), .PERST_TICKS(PERST),
    .POST_TICKS(POST), .FIRST_TICKS(FIRST), .POLL_TICKS(POLL),
    .STABLE_TICKS(STABLE), .ELEC_RETRIES(ELEC), .TRAIN_RETRIES(TRAIN),
    .MAX_RETRIES(MAXR), .CHECK_W(CW)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .tick(tick),
    .slotPresent(slotPresent), .inbandPresent(inbandPresent),
    .linkActive(linkActive), .fenced(fenced), .stableChecks(stableChecks),
    .ctrlReset(ctrlReset), .perstN(perstN), .ready(ready), .failed(failed),
    .cause(cause)
  );

  int nChecks = 0, nFails = 0;
  logic statClr = 0;
  int cyc, perstLow, crstHigh, crstPulses, perstFalls, readySeen;
  int perstRiseCyc, crstFallCyc, doneCyc;
  logic prevPerst, prevCrst, prevDone, doneSeen;

  always @(negedge clk) begin
    if (statClr) begin
      cyc = 0; perstLow = 0; crstHigh = 0; crstPulses = 0; perstFalls = 0;
      readySeen = 0; perstRiseCyc = 0; crstFallCyc = 0; doneCyc = 0;
      doneSeen = 0;
    end else begin
      cyc++;
      if (!perstN) perstLow++;
      if (ctrlReset) crstHigh++;
      if (ctrlReset && !prevCrst) crstPulses++;
      if (!ctrlReset && prevCrst) crstFallCyc = cyc;
      if (!perstN && prevPerst) perstFalls++;
      if (perstN && !prevPerst) perstRiseCyc = cyc;
      if (ready) readySeen++;
      if ((ready || failed) && !prevDone) begin doneCyc = cyc; doneSeen = 1; end
    end
    prevPerst = perstN;
    prevCrst  = ctrlReset;
    prevDone  = ready || failed;
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive();
    @(posedge clk); #2;
  endtask

  task automatic startRun();
    drive(); startPulse = 1; statClr = 1;
    drive(); startPulse = 0; statClr = 0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 20000; i++) begin
      drive();
      if (doneSeen) return;
    end
    nChecks++; nFails++;
    $display("FAIL R9: run never finished, actual 0 expected 1");
  endtask

  function automatic int readyTime(int k);
    return (POST + 1) + (FIRST + 1) + (FIRST + 1) + (k + 1) * (STABLE + 1);
  endfunction

  initial begin
    #1000000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) drive();
    rstN = 1;
    drive();
    #2;
    // reset state: R3 perstN low, R9 flags clear
    check("R3 reset perstN", perstN, 0);
    check("R2 reset ctrlReset", ctrlReset, 0);
    check("R9 reset ready", ready, 0);
    check("R9 reset failed", failed, 0);
    check("R9 reset cause", cause, 0);

    // R1 empty slot
    slotPresent = 0;
    startRun();
    drive(); drive();
    check("R1 empty failed", failed, 1);
    check("R1 empty cause", cause, 1);
    check("R1 empty no ctrlReset", crstPulses, 0);
    check("R1 empty perstN kept", perstN, 0);

    // cold run: assert phase skipped (R3), settle gap (R2), ready timing (R7), mid-run start ignored (R9)
    slotPresent = 1; inbandPresent = 1; linkActive = 1; fenced = 0; stableChecks = 2;
    startRun();
    repeat (10) drive();
    startPulse = 1; drive(); startPulse = 0;
    waitDone();
    check("R7 cold ready", ready, 1);
    check("R9 cold cause", cause, 0);
    check("R3 cold assert skipped", perstFalls, 0);
    check("R2 ctrlReset length", crstHigh, CRST + 1);
    check("R2 settle gap", perstRiseCyc - crstFallCyc, SETTLE + 1);
    check("R7 release-to-ready k=2", doneCyc - perstRiseCyc, readyTime(2));

    // R9 start while ready clears it; R3 assert phase with tick gap (R10)
    stableChecks = 1;
    startRun();
    check("R9 start clears ready", ready, 0);
    while (perstN) drive();
    drive(); drive();
    tick = 0;
    repeat (20) drive();
    tick = 1;
    waitDone();
    check("R3 one assert pulse", perstFalls, 1);
    check("R10 perst low stretched", perstLow, PERST + 1 + 20);
    check("R7 ready after gap", ready, 1);

    // R4 no in-band presence
    inbandPresent = 0;
    startRun();
    waitDone();
    check("R4 failed", failed, 1);
    check("R4 cause", cause, 2);
    check("R4 no retry", crstPulses, 1);
    check("R4 give-up time", doneCyc - perstRiseCyc,
          (POST + 1) + (FIRST + 1) + ELEC * (POLL + 1));

    // R5/R6 link never trains
    inbandPresent = 1; linkActive = 0;
    startRun();
    waitDone();
    check("R6 cause", cause, 3);
    check("R6 attempts", crstPulses, MAXR + 1);
    check("R6 perst pulses", perstFalls, MAXR + 1);
    check("R6 never ready", readySeen, 0);
    check("R5 train window", doneCyc - perstRiseCyc,
          (POST + 1) + (FIRST + 1) + (FIRST + 1) + TRAIN * (POLL + 1));

    // R8 fenced during stability
    linkActive = 1; fenced = 1; stableChecks = 0;
    startRun();
    waitDone();
    check("R8 cause", cause, 4);
    check("R8 attempts", crstPulses, MAXR + 1);

    // R8 fence clears on second attempt -> ready
    fenced = 1;
    startRun();
    while (crstPulses < 2 && !doneSeen) drive();
    fenced = 0;
    waitDone();
    check("R8 recovered ready", ready, 1);
    check("R8 recovered attempts", crstPulses, 2);

    // R7 sweep of stability check counts
    for (int k = 0; k < (1 << CW); k++) begin
      stableChecks = CW'(k);
      startRun();
      waitDone();
      check("R7 sweep ready", ready, 1);
      check("R7 sweep timing", doneCyc - perstRiseCyc, readyTime(k));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule